// File: doc/BRIEF.md
# Zero-Delay PLL Bring-Up Sequencer

This block brings an external clock-conditioning PLL up into zero-delay mode by a three-wire serial write path (serial clock, serial data, latch enable). A single start pulse runs a fixed two-phase procedure. Phase one forces a device reset, writes the full set of configuration words with zero-delay mode off and then starts the frequency calibration. The block then waits for calibration to finish. It either watches the lock-detect pin or, when monitoring is not selected, waits a fixed time. Phase two raises the output-enable and sync pins, rewrites register 0 with zero-delay mode on, and rewrites register 15 with the feedback divider value that suits the longer feedback path.

The configuration images are static input ports that must be held stable while the sequencer is busy. They are indexed by register address (32 bits per slot, 16 slots). The sequencer forces the address field and the reset and mode bits it owns. The serial side is a fixed pin protocol and has no back-pressure, so there is no valid/ready stream at either edge. Control (start, monitor select) and status (busy, done, error) are plain level pins.

Top module: `zdly_cfg_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, out_en_o, sync_o, sck_o, sdo_o and le_o are all 0.
- R2: Each write is 32 bits, most significant bit first. sdo_o changes only when sck_o falls or is low, and sck_o has a period of 2*SCK_HALF clocks. After bit 32, le_o is high for exactly 2*SCK_HALF clocks while sck_o stays low.
- R3: One accepted start produces exactly 17 writes to these register addresses, in this order: 0, 0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 11, 13, 14, 15, 0, 15. Bits [3:0] of every word carry that address.
- R4: The first write is the reset word 32'h8000_0000: bit 31 (reset) is set and every other bit is 0.
- R5: The second write carries bits [28:4] of the register-0 image, with bit 31 (reset) = 0, bit 30 (zero-delay) = 0 and bit 29 (lock-detect reports calibration done) = 1. Writes 3 to 15 carry bits [31:4] of the image at their address.
- R6: out_en_o and sync_o are 0 from the start through the end of phase one. Both are 1 before the phase-two register-0 write is latched, and they stay 1 after done.
- R7: With monitoring selected, calibration ends when the lock pin is seen high. out_en_o rises two clocks after the first clock edge that samples lock_det_i high.
- R8: With monitoring selected, lock_det_i must be sampled high no later than clock edge TMO_CYC-1 after the edge on which le_o falls at the end of the first register-15 write. Otherwise err_o is set, busy_o drops, out_en_o and sync_o stay 0 and no further write occurs. A lock sample that meets the timeout in the same clock wins.
- R9: Without monitoring, lock_det_i is ignored and out_en_o rises exactly WAIT_CYC+1 clocks after the edge on which le_o falls at the end of the first register-15 write.
- R10: Write 16 equals write 2 with bit 30 (zero-delay) set. Write 17 carries bits [31:4] of n_img_i with address 15.
- R11: A start pulse while busy_o is 1 is ignored: the run completes with the same 17 writes. done_o and err_o hold until the next accepted start, and they are never both 1.
- R12: The monitor select ld_mon_en_i is sampled only when start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start request |
| ld_mon_en_i | input | 1 | 1: watch lock pin with timeout; 0: fixed wait |
| lock_det_i | input | 1 | Calibration-complete pin from the device (asynchronous) |
| reg_img_i | input | 512 | 16 register images of 32 bits, slot a at bits [32a+31:32a] |
| n_img_i | input | 32 | Register-15 image for phase two (new feedback divider) |
| busy_o | output | 1 | Procedure in progress |
| done_o | output | 1 | Last run completed |
| err_o | output | 1 | Last run timed out waiting for calibration |
| out_en_o | output | 1 | Global output-enable pin |
| sync_o | output | 1 | Output sync pin |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data |
| le_o | output | 1 | Serial latch enable |

## Verification
Two events can land in the same clock. The synchronized lock-detect sample can arrive on the same edge on which the calibration timeout expires. The bench finds the edge on which the latch enable falls after the first register-15 write. It then raises the lock pin at offsets swept from TMO_CYC-4 to TMO_CYC clocks later, and offset TMO_CYC-2 makes the two coincide. For each offset it predicts from R7 and R8 whether the run ends in done or in error, and it checks the exact cycle on which out-enable rises.

// File: rtl/zdly_pkg.sv
package zdly_pkg;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int NSLOT   = 1 << ADDR_W;
  localparam int NWRITE  = 17;
  localparam int IDX_W   = $clog2(NWRITE);
  localparam int LAST_P1 = 14;   // index of the calibration-starting write
  localparam int P2_R0   = 15;   // index of the phase-two register-0 write
  localparam int BIT_RST = 31;
  localparam int BIT_ZDM = 30;
  localparam int BIT_LDM = 29;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_CAL} seq_st_e;

  // register address for each write slot of the procedure
  function automatic logic [ADDR_W-1:0] seq_addr(input logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] a;
    case (idx)
      5'd0, 5'd15: a = 4'd0;
      5'd9:        a = 4'd8;
      5'd10:       a = 4'd9;
      5'd11:       a = 4'd11;
      5'd12:       a = 4'd13;
      5'd13:       a = 4'd14;
      5'd14, 5'd16: a = 4'd15;
      default:     a = ADDR_W'(idx - 5'd1);
    endcase
    return a;
  endfunction
endpackage

// File: rtl/zdly_bit_sync.sv
module zdly_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff_q <= '0;
        else        ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff_q <= '0;
        else        ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/zdly_wait_timer.sv
module zdly_wait_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  // expiry is reached on the limit_i-th evaluation after a clear
  assign expired_o = (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/zdly_ser_tx.sv
module zdly_ser_tx #(
  parameter int WORD_W   = 32,
  parameter int SCK_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              done_o,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              le_o
);
  localparam int DIV_W = $clog2(2 * SCK_HALF + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [DIV_W-1:0] HALF_END  = DIV_W'(SCK_HALF - 1);
  localparam logic [DIV_W-1:0] LATCH_END = DIV_W'(2 * SCK_HALF - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

  logic              busy_q, latch_q, hi_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sh_q;

  assign sdo_o = sh_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; latch_q <= 1'b0; hi_q <= 1'b0;
      div_q <= '0; bit_q <= '0; sh_q <= '0;
      sck_o <= 1'b0; le_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1; latch_q <= 1'b0; hi_q <= 1'b0;
          div_q <= '0; bit_q <= '0; sh_q <= word_i; sck_o <= 1'b0;
        end
      end else if (latch_q) begin
        if (div_q == LATCH_END) begin
          le_o <= 1'b0; latch_q <= 1'b0; busy_q <= 1'b0;
          done_o <= 1'b1; div_q <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end else if (div_q == HALF_END) begin
        div_q <= '0;
        if (!hi_q) begin
          sck_o <= 1'b1; hi_q <= 1'b1;
        end else begin
          sck_o <= 1'b0; hi_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            le_o <= 1'b1; latch_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zdly_cfg_seq.sv
module zdly_cfg_seq
  import zdly_pkg::*;
#(
  parameter int SCK_HALF  = 4,
  parameter int TMO_CYC   = 1_000_000,
  parameter int WAIT_CYC  = 500_000,
  parameter int SYNC_STG  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    ld_mon_en_i,
  input  logic                    lock_det_i,
  input  logic [NSLOT*WORD_W-1:0] reg_img_i,
  input  logic [WORD_W-1:0]       n_img_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic                    out_en_o,
  output logic                    sync_o,
  output logic                    sck_o,
  output logic                    sdo_o,
  output logic                    le_o
);
  localparam int MAX_CYC = (TMO_CYC > WAIT_CYC) ? TMO_CYC : WAIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [IDX_W-1:0] IDX_P1 = IDX_W'(LAST_P1);
  localparam logic [IDX_W-1:0] IDX_R0B = IDX_W'(P2_R0);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NWRITE - 1);

  seq_st_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic              issued_q, mon_q;
  logic              tx_start, tx_done, ld_s, tmr_exp, tmr_clr;
  logic [CNT_W-1:0]  tmr_lim;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] img, word;

  // ---------------- word assembly ----------------
  assign addr = seq_addr(idx_q);
  assign img  = reg_img_i[int'(addr)*WORD_W +: WORD_W];

  always_comb begin
    word = {img[WORD_W-1:ADDR_W], addr};
    if (idx_q == '0) begin
      word = '0;
      word[BIT_RST] = 1'b1;
    end else if (idx_q == IDX_END) begin
      word = {n_img_i[WORD_W-1:ADDR_W], addr};
    end else if (addr == '0) begin
      word[BIT_RST] = 1'b0;
      word[BIT_ZDM] = (idx_q == IDX_R0B);
      word[BIT_LDM] = 1'b1;
    end
  end

  // bits the sequencer always overrides, and slots never written
  logic unused_img_bits;
  always_comb begin
    unused_img_bits = ^n_img_i[ADDR_W-1:0] ^ ^reg_img_i[10*WORD_W +: WORD_W]
                    ^ ^reg_img_i[12*WORD_W +: WORD_W];
    for (int s = 0; s < NSLOT; s++)
      unused_img_bits = unused_img_bits ^ ^reg_img_i[s*WORD_W +: ADDR_W];
  end

  // ---------------- sub-blocks ----------------
  zdly_ser_tx #(.WORD_W(WORD_W), .SCK_HALF(SCK_HALF)) u_tx (
    .clk(clk), .rst_n(rst_n), .start_i(tx_start), .word_i(word),
    .done_o(tx_done), .sck_o(sck_o), .sdo_o(sdo_o), .le_o(le_o)
  );

  zdly_bit_sync #(.STAGES(SYNC_STG)) u_ldsync (
    .clk(clk), .rst_n(rst_n), .d_i(lock_det_i), .q_o(ld_s)
  );

  assign tmr_clr = (st_q != ST_CAL);
  assign tmr_lim = mon_q ? CNT_W'(TMO_CYC) : CNT_W'(WAIT_CYC);

  zdly_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .limit_i(tmr_lim),
    .expired_o(tmr_exp)
  );

  // ---------------- sequencing ----------------
  assign tx_start = (st_q == ST_SEND) && !issued_q;
  assign busy_o   = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; issued_q <= 1'b0; mon_q <= 1'b0;
      done_o <= 1'b0; err_o <= 1'b0; out_en_o <= 1'b0; sync_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_SEND; idx_q <= '0; issued_q <= 1'b0;
          mon_q <= ld_mon_en_i; done_o <= 1'b0; err_o <= 1'b0;
          out_en_o <= 1'b0; sync_o <= 1'b0;
        end
        ST_SEND: begin
          if (!issued_q) begin
            issued_q <= 1'b1;
          end else if (tx_done) begin
            issued_q <= 1'b0;
            if (idx_q == IDX_P1) begin
              st_q <= ST_CAL;
            end else if (idx_q == IDX_END) begin
              st_q <= ST_IDLE; done_o <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_CAL: begin
          // a lock sample wins over a timeout in the same cycle
          if ((mon_q && ld_s) || (!mon_q && tmr_exp)) begin
            st_q <= ST_SEND; idx_q <= IDX_R0B; issued_q <= 1'b0;
            out_en_o <= 1'b1; sync_o <= 1'b1;
          end else if (mon_q && tmr_exp) begin
            st_q <= ST_IDLE; err_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/zdly_cfg_seq_chk.sv
module zdly_cfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic out_en_o,
  input logic sync_o,
  input logic sck_o,
  input logic sdo_o,
  input logic le_o
);
  // R2: latch enable only with the serial clock low
  a_r2_le_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    le_o |-> !sck_o);

  // R2: data does not move while the serial clock stays high
  a_r2_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(sdo_o));

  // R2: no serial activity outside a run
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!le_o && !sck_o));

  // R11: done and error are exclusive and only shown when not busy
  a_r11_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> (!busy_o && !(done_o && err_o)));

  // R11: a start while busy does not end the run without a flag
  a_r11_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o || err_o));

  // R6: output enable only rises inside a run
  a_r6_oe_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_o) |-> busy_o);

  // R8: a timed-out run leaves both pins low
  a_r8_err_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!out_en_o && !sync_o));
endmodule

bind zdly_cfg_seq zdly_cfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .out_en_o(out_en_o), .sync_o(sync_o),
  .sck_o(sck_o), .sdo_o(sdo_o), .le_o(le_o)
);

// File: tb/zdly_cfg_seq_bench.sv
module zdly_cfg_seq_bench;
  localparam int HALF = 2;
  localparam int TMO  = 300;
  localparam int WAIT = 120;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mon = 1'b0, lock = 1'b0;
  logic [16*32-1:0] img = '0;
  logic [31:0] nimg = '0;
  logic busy, done, err, oe, syn, sck, sdo, le;

  always #2 clk = ~clk;  // 250 MHz

  zdly_cfg_seq #(.SCK_HALF(HALF), .TMO_CYC(TMO), .WAIT_CYC(WAIT)) u_zdly_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ld_mon_en_i(mon),
    .lock_det_i(lock), .reg_img_i(img), .n_img_i(nimg), .busy_o(busy),
    .done_o(done), .err_o(err), .out_en_o(oe), .sync_o(syn),
    .sck_o(sck), .sdo_o(sdo), .le_o(le)
  );

  int nchk = 0, nerr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- serial receiver ----------------
  logic [31:0] sh = '0;
  int nbit = 0, nrx = 0;
  logic [31:0] rx_w [0:511];
  int          rx_b [0:511];
  logic        rx_oe[0:511], rx_sy[0:511];

  always @(posedge sck) begin sh = {sh[30:0], sdo}; nbit++; end
  always @(posedge le) begin
    rx_w[nrx] = sh; rx_b[nrx] = nbit; rx_oe[nrx] = oe; rx_sy[nrx] = syn;
    nbit = 0; nrx++;
  end

  // timing monitor for serial clock period and latch width
  int cyc = 0, last_rise = -1, le_len = 0, per_bad = 0, le_bad = 0;
  logic sck_p = 1'b0, le_p = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (sck && !sck_p) begin
      if (last_rise >= 0 && cyc - last_rise != 2*HALF) per_bad++;
      last_rise = cyc;
    end
    if (le) begin
      le_len++;
      if (sck) le_bad++;
    end
    if (!le && le_p) begin
      if (le_len != 2*HALF) le_bad++;
      le_len = 0; last_rise = -1;
    end
    sck_p = sck; le_p = le;
  end

  // ---------------- reference model ----------------
  function automatic int ord(input int i);
    int t[17] = '{0,0,1,2,3,4,5,6,7,8,9,11,13,14,15,0,15};
    return t[i];
  endfunction

  function automatic logic [31:0] exp_word(input int i);
    int a;
    logic [31:0] w;
    a = ord(i);
    if (i == 0) return 32'h8000_0000;
    if (i == 16) return {nimg[31:4], 4'hF};
    w = {img[a*32+4 +: 28], 4'(a)};
    if (a == 0) begin
      w[31] = 1'b0; w[30] = (i == 15); w[29] = 1'b1;
    end
    return w;
  endfunction

  // ---------------- one run ----------------
  // m: monitor select; d: lock raised d cycles after first R15 latch ends
  // (d<0: never); poke: extra start during phase one
  task automatic run(input bit m, input int d, input bit poke, input string tag);
    int base, c, oe_c;
    bit exp_err;
    int per0, le0;
    base = nrx; per0 = per_bad; le0 = le_bad;
    for (int s = 0; s < 16; s++) img[s*32 +: 32] = $urandom;
    nimg = $urandom;
    exp_err = m && (d < 0 || d > TMO - 2);
    @(negedge clk); mon = m; start = 1'b1;
    @(negedge clk); start = 1'b0; mon = ~m;   // R12: later changes ignored
    chk(busy == 1'b1 && done == 1'b0, "R11", {tag, " busy after start"}, busy, 1);
    chk(oe == 1'b0 && syn == 1'b0, "R6", {tag, " pins low in phase one"}, {oe, syn}, 0);
    if (poke) begin
      while (nrx < base + 3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!(nrx == base + 15 && !le)) @(negedge clk);
    c = 0; oe_c = -1;
    if (!m) lock = 1'b1;                     // R9: must be ignored
    while (!(done || err)) begin
      if (m && c == d) lock = 1'b1;
      if (oe && oe_c < 0) oe_c = c;
      @(negedge clk); c++;
    end
    lock = 1'b0;
    if (exp_err) begin
      chk(err && !done && !busy, "R8", {tag, " timeout error"}, {err, done, busy}, 3'b100);
      chk(!oe && !syn, "R8", {tag, " pins low after timeout"}, {oe, syn}, 0);
      repeat (40) @(negedge clk);
      chk(nrx - base == 15, "R8", {tag, " no writes after timeout"}, nrx - base, 15);
    end else begin
      chk(done && !err && !busy, "R11", {tag, " done"}, {done, err, busy}, 3'b100);
      chk(nrx - base == 17, "R3", {tag, " write count"}, nrx - base, 17);
      for (int i = 0; i < 17; i++) begin
        string rq;
        rq = (i == 0) ? "R4" : (i == 1) ? "R5" : (i >= 15) ? "R10" : "R3";
        chk(rx_w[base+i] == exp_word(i), rq, $sformatf("%s word %0d", tag, i),
            rx_w[base+i], exp_word(i));
        chk(rx_b[base+i] == 32, "R2", $sformatf("%s bits %0d", tag, i), rx_b[base+i], 32);
      end
      for (int i = 0; i < 15; i++)
        if (rx_oe[base+i] || rx_sy[base+i])
          chk(1'b0, "R6", $sformatf("%s pins at write %0d", tag, i), 1, 0);
      chk(rx_oe[base+15] && rx_sy[base+15], "R6", {tag, " pins high at phase two"},
          {rx_oe[base+15], rx_sy[base+15]}, 2'b11);
      chk(oe && syn, "R6", {tag, " pins high after done"}, {oe, syn}, 2'b11);
      if (m) chk(oe_c == d + 3, "R7", {tag, " out-enable rise cycle"}, oe_c, d + 3);
      else   chk(oe_c == WAIT + 1, "R9", {tag, " fixed wait length"}, oe_c, WAIT + 1);
    end
    chk(per_bad == per0 && le_bad == le0, "R2", {tag, " sck period / le width"},
        per_bad - per0, le_bad - le0);
    repeat (3) @(negedge clk);
    chk(done == !exp_err && err == exp_err, "R11", {tag, " flags hold"}, {done, err},
        {!exp_err, exp_err});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (4) @(negedge clk);
    chk({busy, done, err, oe, syn, sck, sdo, le} == 8'h00, "R1", "reset outputs",
        {busy, done, err, oe, syn, sck, sdo, le}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, err, oe, syn, sck, sdo, le} == 8'h00, "R1", "idle outputs",
        {busy, done, err, oe, syn, sck, sdo, le}, 0);
    run(1'b1, 10, 1'b1, "mon d=10 poke");     // R11 ignored start
    run(1'b0, 0, 1'b0, "fixed wait");          // R9, R12
    run(1'b1, -1, 1'b0, "never locks");        // R8
    // coincidence sweep: d=TMO-2 lands on the expiry edge
    for (int d = TMO - 4; d <= TMO; d++) run(1'b1, d, 1'b0, $sformatf("sweep d=%0d", d));
    for (int k = 0; k < 4; k++) begin
      bit m;
      m = 1'($urandom);
      run(m, int'($urandom % (TMO - 1)), 1'($urandom), $sformatf("rand %0d", k));
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule